// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block counts down a relative interval measured in seconds and flags the moment that interval runs out. Software writes the number of seconds into a load register and then sets a run bit. Each one-second tick then takes one off the remaining count. The tick that brings the count to zero sets a sticky pending bit, and counting stops there. Software clears the pending bit by writing a one to it.

Two outputs follow the pending bit. An interrupt line is driven when the interrupt enable is set. A wakeup line is driven when the wakeup enable is set. The two enables are independent, so the alarm can wake a sleeping system without also raising an interrupt, or the reverse.

A second, calendar-based alarm shares the register space but is not built here. Its three register slots always read zero and ignore writes, so software that clears them at start-up sees them in the expected state.

Top module: `secs_alarm`

## Requirements
- R1: After reset, the remaining count, the loaded value, the run bit, both enables and the pending bit are all zero, and both outputs are low.
- R2: A write to offset 0x20 loads the full 32-bit word as the remaining count. Offset 0x24 reads back the remaining count, and offset 0x20 reads back the last loaded value.
- R3: A tick while the run bit (offset 0x28, bit 0) is set and the count is nonzero lowers the count by exactly one. A tick while the run bit is clear leaves the count unchanged.
- R4: The tick that takes the count from one to zero sets the pending bit (offset 0x30, bit 0). The count then stays at zero under further ticks.
- R5: Loading zero never sets the pending bit, and clearing the run bit part-way through a countdown never sets it either.
- R6: Writing a one to bit 0 of offset 0x30 clears the pending bit, and writing a zero there leaves it unchanged. If a clear and the zero-reaching tick fall in the same cycle, the pending bit ends up set.
- R7: The interrupt output is high exactly when the pending bit and the interrupt enable (offset 0x2C, bit 0) are both set.
- R8: The wakeup output is high exactly when the pending bit and the wakeup enable (offset 0x50, bit 0) are both set.
- R9: Offsets 0x44, 0x48 and 0x4C always read zero, and writing all ones to them changes no output and no other register.
- R10: A load during a countdown restarts it from the new value. A load in the same cycle as a tick takes the loaded value and skips that tick's decrement.
- R11: Only bit 0 of the run, interrupt-enable and wakeup-enable registers is stored. Their other bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_1hz | input | 1 | One-cycle pulse per elapsed second |
| irq_out | output | 1 | Alarm interrupt |
| wake_out | output | 1 | Alarm wakeup request |

## Verification
The bench aims at the cycle where the count moves from one to zero. If the zero test were made on the wrong side of the decrement, the pending bit would show up one tick early or late, or it would fire when zero is loaded or when counting is stopped part-way. The bench also makes a clear and the zero-reaching tick land in the same cycle; a design with the priority reversed would drop the alarm without any trace. A load that coincides with a tick is checked as well, because a design that let the decrement win would come out one second short. Finally, all ones are written to the unused calendar-alarm slots, so that sloppy address decoding would show up as a changed enable or an output going high.

// File: rtl/secs_alarm_pkg.sv
package secs_alarm_pkg;
  localparam logic [7:0] OFS_LOAD   = 8'h20;
  localparam logic [7:0] OFS_REMAIN = 8'h24;
  localparam logic [7:0] OFS_RUN    = 8'h28;
  localparam logic [7:0] OFS_IE     = 8'h2C;
  localparam logic [7:0] OFS_STAT   = 8'h30;
  localparam logic [7:0] OFS_CAL_EN = 8'h44;
  localparam logic [7:0] OFS_CAL_IE = 8'h48;
  localparam logic [7:0] OFS_CAL_ST = 8'h4C;
  localparam logic [7:0] OFS_WAKE   = 8'h50;

  localparam int unsigned NUM_CTL = 3;

  typedef enum logic [1:0] {CTL_RUN = 2'd0, CTL_IE = 2'd1, CTL_WAKE = 2'd2} ctl_idx_e;

  typedef struct packed {
    logic wake_en;
    logic irq_en;
    logic run;
  } ctl_t;
endpackage

// File: rtl/secs_alarm_regs.sv
module secs_alarm_regs
  import secs_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count_q,
  input  logic              pend_q,
  output logic              load_ev,
  output logic [CNT_W-1:0]  load_val,
  output logic              clr_ev,
  output ctl_t              ctl,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [7:0] CTL_OFS [NUM_CTL] = '{OFS_RUN, OFS_IE, OFS_WAKE};

  logic [CNT_W-1:0] loaded_q;
  logic [NUM_CTL-1:0] ctl_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  function automatic logic [DATA_W-1:0] widen(input logic [CNT_W-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[CNT_W-1:0] = v;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] bit0(input logic b);
    logic [DATA_W-1:0] r;
    r = '0;
    r[0] = b;
    return r;
  endfunction

  assign load_ev  = bus_wr && hit(bus_addr, OFS_LOAD);
  assign load_val = bus_wdata[CNT_W-1:0];
  assign clr_ev   = bus_wr && hit(bus_addr, OFS_STAT) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       loaded_q <= '0;
    else if (load_ev) loaded_q <= load_val;
  end

  for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ctl_q[g] <= 1'b0;
      else if (bus_wr && hit(bus_addr, CTL_OFS[g]))
        ctl_q[g] <= bus_wdata[0];
    end
  end

  assign ctl.run     = ctl_q[CTL_RUN];
  assign ctl.irq_en  = ctl_q[CTL_IE];
  assign ctl.wake_en = ctl_q[CTL_WAKE];

  always_comb begin
    bus_rdata = '0;
    if (hit(bus_addr, OFS_LOAD))   bus_rdata = widen(loaded_q);
    if (hit(bus_addr, OFS_REMAIN)) bus_rdata = widen(count_q);
    if (hit(bus_addr, OFS_STAT))   bus_rdata = bit0(pend_q);
    for (int i = 0; i < NUM_CTL; i++)
      if (hit(bus_addr, CTL_OFS[i])) bus_rdata = bit0(ctl_q[i]);
  end
endmodule

// File: rtl/secs_alarm_count.sv
module secs_alarm_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_ev,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] count_q,
  output logic             dec_ev,
  output logic             zero_ev
);
  function automatic logic may_step(input logic t, input logic r,
                                    input logic ld, input logic [CNT_W-1:0] c);
    return t && r && !ld && (c != '0);
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic ld, input logic [CNT_W-1:0] lv,
                                                  input logic st, input logic [CNT_W-1:0] c);
    if (ld)      return lv;
    else if (st) return c - CNT_W'(1);
    else         return c;
  endfunction

  assign dec_ev  = may_step(tick, run, load_ev, count_q);
  assign zero_ev = dec_ev && (count_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= next_count(load_ev, load_val, dec_ev, count_q);
  end
endmodule

// File: rtl/secs_alarm_flag.sv
module secs_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_ev,
  input  logic clr_ev,
  input  logic irq_en,
  input  logic wake_en,
  output logic pend_q,
  output logic irq_out,
  output logic wake_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (zero_ev) pend_q <= 1'b1;
    else if (clr_ev)  pend_q <= 1'b0;
  end

  assign irq_out  = pend_q && irq_en;
  assign wake_out = pend_q && wake_en;
endmodule

// File: rtl/secs_alarm.sv
module secs_alarm
  import secs_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_1hz,
  output logic              irq_out,
  output logic              wake_out
);
  logic             load_ev, clr_ev, dec_ev, zero_ev, pend_q;
  logic [CNT_W-1:0] load_val, count_q;
  ctl_t             ctl;

  secs_alarm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .count_q(count_q), .pend_q(pend_q),
    .load_ev(load_ev), .load_val(load_val), .clr_ev(clr_ev), .ctl(ctl),
    .bus_rdata(bus_rdata)
  );

  secs_alarm_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load_ev(load_ev), .load_val(load_val),
    .run(ctl.run), .tick(tick_1hz), .count_q(count_q),
    .dec_ev(dec_ev), .zero_ev(zero_ev)
  );

  secs_alarm_flag u_flag (
    .clk(clk), .rst_n(rst_n), .zero_ev(zero_ev), .clr_ev(clr_ev),
    .irq_en(ctl.irq_en), .wake_en(ctl.wake_en), .pend_q(pend_q),
    .irq_out(irq_out), .wake_out(wake_out)
  );
endmodule

// File: rtl/secs_alarm_chk.sv
module secs_alarm_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             run,
  input logic             irq_en,
  input logic             wake_en,
  input logic             load_ev,
  input logic             clr_ev,
  input logic             zero_ev,
  input logic             pend_q,
  input logic [CNT_W-1:0] count_q,
  input logic             irq_out,
  input logic             wake_out
);
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !load_ev && count_q != '0) |=> (count_q == $past(count_q) - CNT_W'(1)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ev && !(tick && run)) |=> $stable(count_q));

  assert_pend_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(tick && run && !load_ev && count_q == CNT_W'(1)));

  assert_no_set_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && !pend_q) |=> !pend_q);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !zero_ev) |=> !pend_q);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    zero_ev |=> pend_q);

  assert_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (pend_q && irq_en));

  assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_out == (pend_q && wake_en));
endmodule

bind secs_alarm secs_alarm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .run(ctl.run),
  .irq_en(ctl.irq_en), .wake_en(ctl.wake_en), .load_ev(load_ev),
  .clr_ev(clr_ev), .zero_ev(zero_ev), .pend_q(pend_q), .count_q(count_q),
  .irq_out(irq_out), .wake_out(wake_out)
);

// File: tb/sim_secs_alarm.sv
`timescale 1ns/1ps
module sim_secs_alarm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_1hz = 1'b0;
  logic        irq_out, wake_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  secs_alarm u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_1hz(tick_1hz),
    .irq_out(irq_out), .wake_out(wake_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle; optional write and tick in the same cycle
  task automatic cyc(input bit wr, input logic [7:0] a, input logic [31:0] d, input bit tk);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; tick_1hz = tk;
    @(negedge clk);
    bus_wr = 1'b0; tick_1hz = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 32'h0, 1'b1);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(8'h24, v); chk("R1 remain", v, 0);
    rd(8'h20, v); chk("R1 loaded", v, 0);
    rd(8'h28, v); chk("R1 run", v, 0);
    rd(8'h2C, v); chk("R1 ie", v, 0);
    rd(8'h50, v); chk("R1 wake en", v, 0);
    rd(8'h30, v); chk("R1 pend", v, 0);
    chk("R1 outs", {30'b0, irq_out, wake_out}, 0);
  endtask

  task automatic t_load();
    logic [31:0] v;
    do_reset();
    wr(8'h20, 32'hDEAD_BEEF);
    rd(8'h24, v); chk("R2 remain", v, 32'hDEAD_BEEF);
    rd(8'h20, v); chk("R2 loaded", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_count();
    logic [31:0] v;
    do_reset();
    wr(8'h20, 32'd10);
    tick(3);
    rd(8'h24, v); chk("R3 no run", v, 10);
    wr(8'h28, 32'h1);
    tick(4);
    rd(8'h24, v); chk("R3 four ticks", v, 6);
    repeat (3) @(negedge clk);
    rd(8'h24, v); chk("R3 no tick idle", v, 6);
  endtask

  task automatic t_expire();
    logic [31:0] v;
    do_reset();
    wr(8'h20, 32'd3);
    wr(8'h28, 32'h1);
    tick(2);
    rd(8'h30, v); chk("R4 not yet", v, 0);
    rd(8'h24, v); chk("R4 count one", v, 1);
    tick(1);
    rd(8'h30, v); chk("R4 pend", v, 1);
    tick(2);
    rd(8'h24, v); chk("R4 stays zero", v, 0);
    rd(8'h30, v); chk("R4 pend held", v, 1);
  endtask

  task automatic t_no_false();
    logic [31:0] v;
    do_reset();
    wr(8'h28, 32'h1);
    wr(8'h20, 32'd0);
    tick(3);
    rd(8'h30, v); chk("R5 load zero", v, 0);
    wr(8'h20, 32'd2);
    tick(1);
    wr(8'h28, 32'h0);
    tick(3);
    rd(8'h24, v); chk("R5 stopped count", v, 1);
    rd(8'h30, v); chk("R5 stopped pend", v, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    do_reset();
    wr(8'h28, 32'h1);
    wr(8'h20, 32'd1);
    tick(1);
    wr(8'h30, 32'h0);
    rd(8'h30, v); chk("R6 write zero keeps", v, 1);
    wr(8'h30, 32'h1);
    rd(8'h30, v); chk("R6 w1c", v, 0);
    wr(8'h20, 32'd1);
    cyc(1'b1, 8'h30, 32'h1, 1'b1);
    rd(8'h30, v); chk("R6 set wins", v, 1);
  endtask

  task automatic t_outs();
    do_reset();
    wr(8'h28, 32'h1);
    wr(8'h20, 32'd1);
    tick(1);
    chk("R7 irq off", irq_out, 0);
    chk("R8 wake off", wake_out, 0);
    wr(8'h2C, 32'h1);
    chk("R7 irq on", irq_out, 1);
    chk("R8 wake still off", wake_out, 0);
    wr(8'h50, 32'h1);
    wr(8'h2C, 32'h0);
    chk("R8 wake on", wake_out, 1);
    chk("R7 irq off again", irq_out, 0);
    wr(8'h30, 32'h1);
    wr(8'h2C, 32'h1);
    chk("R7 cleared", irq_out, 0);
    chk("R8 cleared", wake_out, 0);
  endtask

  task automatic t_cal();
    logic [31:0] v;
    do_reset();
    wr(8'h20, 32'd5);
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h48, 32'hFFFF_FFFF);
    wr(8'h4C, 32'hFFFF_FFFF);
    rd(8'h44, v); chk("R9 cal en", v, 0);
    rd(8'h48, v); chk("R9 cal ie", v, 0);
    rd(8'h4C, v); chk("R9 cal st", v, 0);
    rd(8'h28, v); chk("R9 run untouched", v, 0);
    rd(8'h2C, v); chk("R9 ie untouched", v, 0);
    rd(8'h24, v); chk("R9 count untouched", v, 5);
    chk("R9 outs", {30'b0, irq_out, wake_out}, 0);
  endtask

  task automatic t_reload();
    logic [31:0] v;
    do_reset();
    wr(8'h28, 32'h1);
    wr(8'h20, 32'd8);
    tick(3);
    wr(8'h20, 32'd20);
    rd(8'h24, v); chk("R10 restart", v, 20);
    cyc(1'b1, 8'h20, 32'd7, 1'b1);
    rd(8'h24, v); chk("R10 load beats tick", v, 7);
    tick(1);
    rd(8'h24, v); chk("R10 after", v, 6);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    do_reset();
    wr(8'h28, 32'hFFFF_FFFE);
    rd(8'h28, v); chk("R11 run bit0 only", v, 0);
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, v); chk("R11 run", v, 1);
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h2C, v); chk("R11 ie", v, 1);
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h50, v); chk("R11 wake", v, 1);
  endtask

  initial begin
    t_reset();
    t_load();
    t_count();
    t_expire();
    t_no_false();
    t_w1c();
    t_outs();
    t_cal();
    t_reload();
    t_mask();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule